// File: doc/BRIEF.md
# CB Channel Selection Controller

This block owns the selected channel of a 40-channel citizens-band transceiver. It takes debounced key levels (step up, step down, five preset memory keys, a store modifier), two emergency channel switches, a transmit/receive select, a hold select and a synchronous active-low reset. It drives the current channel number and the matching carrier frequency in kHz, which a PLL divider downstream consumes.

Stepping wraps at both ends of the band. Holding a step key long enough starts an automatic scan that keeps going after release until another key is pressed. Five preset slots can be stored and recalled. An emergency switch overrides the shown channel without disturbing the normal selection, so releasing it brings the normal channel back. Hold mode blanks the outputs and freezes the selection until hold is released. The channel-to-frequency map is not a straight line: five 10 kHz slots are skipped, and channels 23 to 25 are out of order. The map therefore carries explicit entries for those channels.

Key inputs are levels. A press is a low-to-high change seen at a clock edge. All timing counts are in clock cycles.

Top module: `cb_chan_ctrl`

## Requirements
- R1: At the first clock edge with `rst_n` low the block enters its initial state. `channel` is 1 and `freq_khz` is 26965. All five presets hold channel 1. `scanning`, `emerg_active`, `in_hold` and `transmit` are 0.
- R2: `freq_khz` gives the carrier of `channel` in kHz. The base is 26965 + 10·(ch−1), plus 10 for each of the boundaries ch≥4, ch≥8, ch≥12, ch≥16 and ch≥20. The exceptions are channel 23 = 27255, channel 24 = 27235 and channel 25 = 27245. Channel 0 gives 0.
- R3: A press of `key_up` or `key_dn` moves the channel by one at the edge where the press is first sampled. Keeping the key held for fewer than HOLD_TICKS further cycles causes no further step. Pressing both keys at the same edge changes nothing.
- R4: Stepping up from 40 gives 1, and stepping down from 1 gives 40.
- R5: A step key still held HOLD_TICKS edges after its press starts a scan at that edge, and `scanning` goes to 1. The scan steps in the key's direction every SCAN_TICKS edges, with the first step SCAN_TICKS edges after the scan starts, and it goes on after the key is released. The next press of any key ends the scan and has no other effect.
- R6: A press on `key_mem[i]` with `mem_store` low loads the channel from preset slot i. If several memory keys are pressed at the same edge, the lowest index wins.
- R7: A press on `key_mem[i]` with `mem_store` high writes the current channel into slot i and leaves the channel unchanged.
- R8: While `emerg19` is high, `channel` is 19. Otherwise, while `emerg9` is high, `channel` is 9. Both take effect one edge after the input is sampled. While either switch is high, key presses are ignored and a running scan is cancelled, including a scan step due at the same edge. After both are released, the previous normal channel returns.
- R9: While `hold_n` is low, `in_hold` is 1 and `channel` and `freq_khz` are 0. In that state keys and emergency switches have no effect and a scan is cancelled. After `hold_n` goes high, the channel held before hold returns.
- R10: `transmit` equals the inverse of `tx_n` as sampled at the previous edge, where low selects transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_up | input | 1 | Step-up key level |
| key_dn | input | 1 | Step-down key level |
| key_mem | input | NUM_PRESETS | Preset keys, bit i selects slot i |
| mem_store | input | 1 | High turns a preset press into a store |
| emerg9 | input | 1 | Emergency channel 9 switch |
| emerg19 | input | 1 | Emergency channel 19 switch, wins over 9 |
| tx_n | input | 1 | Low selects transmit, high receive |
| hold_n | input | 1 | Low enters hold mode |
| channel | output | 6 | Channel shown, 0 in hold |
| freq_khz | output | 15 | Carrier frequency in kHz |
| transmit | output | 1 | High when transmitting |
| in_hold | output | 1 | High in hold mode |
| emerg_active | output | 1 | High while an emergency channel is forced |
| scanning | output | 1 | High while a scan runs |

## Verification
A scan step and the engagement of an emergency switch can land on the same clock edge. The bench starts a scan, counts edges from the scan start, and raises `emerg9` so that it is first sampled exactly at the edge where the first scan step is due. It then expects channel 9 with the scan stopped. After release it expects the channel from before that edge, not one step further, and that channel must stay put for several scan periods.

// File: rtl/cb_pkg.sv
// Shared constants and helpers for the CB channel controller.
// Assumes a 40-channel band numbered 1..40; channel 0 means "blank".
package cb_pkg;
    localparam int CH_W     = 6;
    localparam int FREQ_W   = 15;
    localparam int NUM_CH   = 40;
    localparam int FIRST_CH = 1;

    typedef logic [CH_W-1:0]   chan_t;
    typedef logic [FREQ_W-1:0] khz_t;

    // Next channel upward, wrapping from the top of the band to the bottom.
    function automatic chan_t chan_next(input chan_t c);
        return (c >= chan_t'(NUM_CH)) ? chan_t'(FIRST_CH) : chan_t'(c + chan_t'(1));
    endfunction

    // Next channel downward, wrapping from the bottom of the band to the top.
    function automatic chan_t chan_prev(input chan_t c);
        return (c <= chan_t'(FIRST_CH)) ? chan_t'(NUM_CH) : chan_t'(c - chan_t'(1));
    endfunction
endpackage

// File: rtl/cb_freq_rom.sv
// Channel-to-carrier map in kHz.
// Regular channels follow a 10 kHz grid with a list of skipped slots.
// The three out-of-order channels are held as explicit entries.
// Assumes the input is 0..63; anything outside 1..NUM_CH yields 0.
module cb_freq_rom
    import cb_pkg::*;
#(
    parameter int BASE_KHZ = 26965,
    parameter int STEP_KHZ = 10,
    parameter int GAP_EVERY = 4,
    parameter int GAP_LAST  = 20
) (
    input  chan_t ch,
    output khz_t  khz
);
    localparam int REG_CH_A = 23;
    localparam int REG_CH_B = 24;
    localparam int REG_CH_C = 25;

    // Compute the grid value, then apply the out-of-order entries.
    always_comb begin
        int gaps;
        int val;
        gaps = 0;
        for (int b = GAP_EVERY; b <= GAP_LAST; b += GAP_EVERY) begin
            if (int'(ch) >= b) gaps++;
        end
        val = BASE_KHZ + STEP_KHZ * (int'(ch) - 1 + gaps);
        case (int'(ch))
            REG_CH_A: val = 27255;
            REG_CH_B: val = 27235;
            REG_CH_C: val = 27245;
            default: ;
        endcase
        if (ch == '0 || int'(ch) > NUM_CH) val = 0;
        khz = khz_t'(val);
    end
endmodule

// File: rtl/cb_step_scan.sv
// Step and scan sequencer.
// Detects presses on the step keys, times a long press, and runs the
// automatic scan. Emits one-cycle step pulses.
// Assumes key levels are already debounced and synchronous to clk.
// HOLD_TICKS and SCAN_TICKS must each be at least 2.
module cb_step_scan #(
    parameter int HOLD_TICKS = 500_000,
    parameter int SCAN_TICKS = 250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_up,
    input  logic key_dn,
    input  logic other_press,   // press of any non-step key this cycle
    input  logic cancel,        // hold or emergency: stop everything
    output logic step_up,
    output logic step_dn,
    output logic scanning
);
    localparam int HCW = $clog2(HOLD_TICKS + 1);
    localparam int SCW = $clog2(SCAN_TICKS + 1);

    logic           up_q, dn_q;
    logic           armed, dir_up;
    logic [HCW-1:0] hold_cnt;
    logic [SCW-1:0] scan_cnt;
    logic           press_up, press_dn, any_press, scan_due;

    assign press_up  = key_up & ~up_q;
    assign press_dn  = key_dn & ~dn_q;
    assign any_press = press_up | press_dn | other_press;
    assign scan_due  = scanning & (scan_cnt == SCW'(SCAN_TICKS - 1)) & ~any_press;

    // Step pulses: single presses when idle, timed steps when scanning.
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        if (!cancel) begin
            if (!scanning) begin
                step_up = press_up & ~press_dn;
                step_dn = press_dn & ~press_up;
            end else begin
                step_up = scan_due & dir_up;
                step_dn = scan_due & ~dir_up;
            end
        end
    end

    // Previous key levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= key_up;
            dn_q <= key_dn;
        end
    end

    // Long-press timer and scan state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            dir_up   <= 1'b1;
            hold_cnt <= '0;
            scan_cnt <= '0;
            scanning <= 1'b0;
        end else if (cancel) begin
            armed    <= 1'b0;
            scanning <= 1'b0;
        end else if (scanning) begin
            if (any_press) begin
                scanning <= 1'b0;
            end else if (scan_cnt == SCW'(SCAN_TICKS - 1)) begin
                scan_cnt <= '0;
            end else begin
                scan_cnt <= scan_cnt + SCW'(1);
            end
        end else if (press_up ^ press_dn) begin
            armed    <= 1'b1;
            dir_up   <= press_up;
            hold_cnt <= '0;
        end else if (armed && (dir_up ? key_up : key_dn)) begin
            if (hold_cnt == HCW'(HOLD_TICKS - 1)) begin
                scanning <= 1'b1;
                scan_cnt <= '0;
                armed    <= 1'b0;
            end else begin
                hold_cnt <= hold_cnt + HCW'(1);
            end
        end else begin
            armed <= 1'b0;
        end
    end

    // R3: never a step in both directions at once
    assert_step_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));

    // R9: a cancel always leaves the scan stopped
    assert_cancel_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !scanning);

    // R5: any key press while scanning ends the scan
    assert_press_ends_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && any_press) |=> !scanning);
endmodule

// File: rtl/cb_preset_bank.sv
// Preset channel memory.
// Detects presses on the memory keys, picks the lowest pressed slot,
// and either stores the current channel there or offers it for recall.
// Assumes key levels are debounced and synchronous to clk.
module cb_preset_bank
    import cb_pkg::*;
#(
    parameter int NUM_PRESETS = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PRESETS-1:0] key_mem,
    input  logic                   mem_store,
    input  logic                   enable,
    input  chan_t                  cur_ch,
    output logic                   press_any,
    output logic                   recall_en,
    output chan_t                  recall_ch
);
    logic [NUM_PRESETS-1:0] mem_q, press_vec, sel;
    chan_t                  slot [NUM_PRESETS];

    assign press_vec = key_mem & ~mem_q;
    assign sel       = press_vec & (~press_vec + NUM_PRESETS'(1));
    assign press_any = |press_vec;
    assign recall_en = enable & ~mem_store & press_any;

    // Previous memory key levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= key_mem;
    end

    // Mux the selected slot onto the recall bus.
    always_comb begin
        recall_ch = '0;
        for (int i = 0; i < NUM_PRESETS; i++) begin
            if (sel[i]) recall_ch = slot[i];
        end
    end

    for (genvar g = 0; g < NUM_PRESETS; g++) begin : g_slot
        // Slot register: reset to the first channel, written on a store press.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= chan_t'(FIRST_CH);
            else if (enable && mem_store && sel[g])
                slot[g] <= cur_ch;
        end

        // R7: a store press lands the current channel in its slot
        assert_store_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && mem_store && sel[g]) |=> slot[g] == $past(cur_ch));
    end

    // R6: a recalled value is always a valid channel
    assert_recall_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        recall_en |-> (recall_ch >= chan_t'(FIRST_CH) && recall_ch <= chan_t'(NUM_CH)));
endmodule

// File: rtl/cb_chan_ctrl.sv
// CB channel selection controller (top).
// Keeps the normal channel, applies step, scan and preset actions, and
// overlays the emergency and hold modes on the shown channel.
// Registers the transmit select.
// Assumes every input is synchronous to clk and the keys are debounced.
module cb_chan_ctrl
    import cb_pkg::*;
#(
    parameter int HOLD_TICKS  = 500_000,
    parameter int SCAN_TICKS  = 250_000,
    parameter int NUM_PRESETS = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   key_up,
    input  logic                   key_dn,
    input  logic [NUM_PRESETS-1:0] key_mem,
    input  logic                   mem_store,
    input  logic                   emerg9,
    input  logic                   emerg19,
    input  logic                   tx_n,
    input  logic                   hold_n,
    output logic [CH_W-1:0]        channel,
    output logic [FREQ_W-1:0]      freq_khz,
    output logic                   transmit,
    output logic                   in_hold,
    output logic                   emerg_active,
    output logic                   scanning
);
    localparam chan_t EMERG_LO = chan_t'(9);
    localparam chan_t EMERG_HI = chan_t'(19);

    chan_t ch_norm, recall_ch;
    logic  hold_q, e9_q, e19_q, tx_q;
    logic  blocked, step_up, step_dn, mem_any, recall_en, bank_en;

    assign blocked = ~hold_n | emerg9 | emerg19;
    assign bank_en = ~blocked & ~scanning & ~step_up & ~step_dn;

    cb_step_scan #(
        .HOLD_TICKS (HOLD_TICKS),
        .SCAN_TICKS (SCAN_TICKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_up      (key_up),
        .key_dn      (key_dn),
        .other_press (mem_any),
        .cancel      (blocked),
        .step_up     (step_up),
        .step_dn     (step_dn),
        .scanning    (scanning)
    );

    cb_preset_bank #(
        .NUM_PRESETS (NUM_PRESETS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_mem   (key_mem),
        .mem_store (mem_store),
        .enable    (bank_en),
        .cur_ch    (ch_norm),
        .press_any (mem_any),
        .recall_en (recall_en),
        .recall_ch (recall_ch)
    );

    // Normal channel register: step, scan step or preset recall.
    always_ff @(posedge clk) begin
        if (!rst_n)         ch_norm <= chan_t'(FIRST_CH);
        else if (step_up)   ch_norm <= chan_next(ch_norm);
        else if (step_dn)   ch_norm <= chan_prev(ch_norm);
        else if (recall_en) ch_norm <= recall_ch;
    end

    // Mode and transmit select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            e9_q   <= 1'b0;
            e19_q  <= 1'b0;
            tx_q   <= 1'b0;
        end else begin
            hold_q <= ~hold_n;
            e9_q   <= emerg9;
            e19_q  <= emerg19;
            tx_q   <= ~tx_n;
        end
    end

    // Shown channel: hold blanks, then emergency 19, then 9, then normal.
    always_comb begin
        if (hold_q)     channel = '0;
        else if (e19_q) channel = EMERG_HI;
        else if (e9_q)  channel = EMERG_LO;
        else            channel = ch_norm;
    end

    assign in_hold      = hold_q;
    assign emerg_active = ~hold_q & (e9_q | e19_q);
    assign transmit     = tx_q;

    cb_freq_rom u_rom (
        .ch  (channel),
        .khz (freq_khz)
    );

    // R4: the normal channel never leaves the band
    assert_chan_in_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ch_norm >= chan_t'(FIRST_CH) && ch_norm <= chan_t'(NUM_CH));

    // R4: stepping up from the top lands on the first channel
    assert_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up && ch_norm == chan_t'(NUM_CH)) |=> ch_norm == chan_t'(FIRST_CH));

    // R8: while an override is requested the normal selection is frozen
    assert_override_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> $stable(ch_norm));

    // R8: the high emergency switch wins when hold is off
    assert_emerg_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(emerg19) && $past(hold_n)) |-> channel == EMERG_HI);

    // R9: hold blanks the frequency code
    assert_hold_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold |-> freq_khz == '0);

    // R10: transmit follows the inverted select one edge later
    assert_tx_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> transmit == !$past(tx_n));
endmodule

// File: tb/cb_chan_ctrl_test.sv
// Directed bench for the CB channel controller; one task per scenario.
// Inputs change on the falling edge and outputs are read on the falling edge.
module cb_chan_ctrl_test;
    localparam int HT = 20;
    localparam int ST = 10;
    localparam int NP = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          key_up = 1'b0, key_dn = 1'b0, mem_store = 1'b0;
    logic [NP-1:0] key_mem = '0;
    logic          emerg9 = 1'b0, emerg19 = 1'b0, tx_n = 1'b1, hold_n = 1'b1;
    logic [5:0]    channel;
    logic [14:0]   freq_khz;
    logic          transmit, in_hold, emerg_active, scanning;

    int n_checks = 0;
    int n_err    = 0;

    always #2 clk = ~clk;

    cb_chan_ctrl #(.HOLD_TICKS(HT), .SCAN_TICKS(ST), .NUM_PRESETS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .key_up(key_up), .key_dn(key_dn),
        .key_mem(key_mem), .mem_store(mem_store), .emerg9(emerg9),
        .emerg19(emerg19), .tx_n(tx_n), .hold_n(hold_n), .channel(channel),
        .freq_khz(freq_khz), .transmit(transmit), .in_hold(in_hold),
        .emerg_active(emerg_active), .scanning(scanning)
    );

    function automatic int want_khz(input int c);
        int gaps;
        if (c == 23) return 27255;
        if (c == 24) return 27235;
        if (c == 25) return 27245;
        if (c < 1 || c > 40) return 0;
        gaps = (c >= 20) ? 5 : c / 4;
        return 26965 + 10 * (c - 1) + 10 * gaps;
    endfunction

    function automatic int up1(input int c);   return (c == 40) ? 1 : c + 1; endfunction
    function automatic int dn1(input int c);   return (c == 1) ? 40 : c - 1; endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tap_up();  key_up = 1'b1; cyc(1); key_up = 1'b0; cyc(1); endtask
    task automatic tap_dn();  key_dn = 1'b1; cyc(1); key_dn = 1'b0; cyc(1); endtask
    task automatic tap_mem(input logic [NP-1:0] m, input logic st);
        mem_store = st; key_mem = m; cyc(1); key_mem = '0; mem_store = 1'b0; cyc(1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
    endtask

    // Press and hold a step key until the scan starts; returns the channel after the first step.
    task automatic start_scan(input bit up, output int c1);
        int c0;
        c0 = channel;
        if (up) key_up = 1'b1; else key_dn = 1'b1;
        cyc(1);
        c1 = up ? up1(c0) : dn1(c0);
        chk("R3", "press step", channel, c1);
        cyc(HT - 1);
        chk("R5", "no scan before threshold", scanning, 0);
        cyc(1);
        chk("R5", "scan starts at threshold", scanning, 1);
        key_up = 1'b0; key_dn = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "channel", channel, 1);
        chk("R1", "freq", freq_khz, 26965);
        chk("R1", "scanning", scanning, 0);
        chk("R1", "emerg", emerg_active, 0);
        chk("R1", "hold", in_hold, 0);
        chk("R1", "transmit", transmit, 0);
    endtask

    task automatic t_walk_table();
        for (int c = 2; c <= 40; c++) begin
            tap_up();
            chk("R3", "walk channel", channel, c);
            chk("R2", "walk freq", freq_khz, want_khz(c));
        end
        tap_up();
        chk("R4", "wrap up", channel, 1);
        tap_dn();
        chk("R4", "wrap down", channel, 40);
        chk("R2", "freq ch40", freq_khz, 27405);
        tap_up();
    endtask

    task automatic t_step_corners();
        key_up = 1'b1; key_dn = 1'b1; cyc(1);
        chk("R3", "both keys no change", channel, 1);
        key_up = 1'b0; key_dn = 1'b0; cyc(1);
        key_up = 1'b1; cyc(HT - 2); key_up = 1'b0; cyc(2);
        chk("R3", "short hold one step", channel, 2);
        chk("R3", "short hold no scan", scanning, 0);
    endtask

    task automatic t_scan();
        int c1;
        start_scan(1'b1, c1);
        cyc(ST - 1);
        chk("R5", "before first scan step", channel, c1);
        cyc(1);
        chk("R5", "first scan step", channel, up1(c1));
        cyc(ST);
        chk("R5", "second scan step", channel, up1(up1(c1)));
        key_dn = 1'b1; cyc(1); key_dn = 1'b0;
        chk("R5", "press ends scan", scanning, 0);
        chk("R5", "ending press no step", channel, up1(up1(c1)));
        cyc(3 * ST);
        chk("R5", "stays after stop", channel, up1(up1(c1)));
        start_scan(1'b0, c1);
        cyc(ST);
        chk("R5", "down scan step", channel, dn1(c1));
        tap_mem(5'b00001, 1'b0);
        chk("R5", "memory press ends scan only", channel, dn1(c1));
        chk("R5", "scan off after memory press", scanning, 0);
    endtask

    task automatic t_presets();
        int x;
        x = channel;
        tap_mem(5'b00100, 1'b1);
        chk("R7", "store keeps channel", channel, x);
        tap_up(); tap_up();
        tap_mem(5'b00100, 1'b0);
        chk("R6", "recall slot 2", channel, x);
        tap_mem(5'b00001, 1'b0);
        chk("R1", "slot 0 reset value", channel, 1);
        tap_up(); tap_up(); tap_up();
        tap_mem(5'b01000, 1'b1);
        tap_mem(5'b01010, 1'b0);
        chk("R6", "lowest index wins", channel, 1);
        tap_mem(5'b01000, 1'b0);
        chk("R7", "slot 3 stored", channel, 4);
    endtask

    task automatic t_emergency();
        int c;
        c = channel;
        emerg9 = 1'b1; cyc(1);
        chk("R8", "ch9 forced", channel, 9);
        chk("R8", "emerg flag", emerg_active, 1);
        tap_up();
        chk("R8", "key ignored", channel, 9);
        emerg19 = 1'b1; cyc(1);
        chk("R8", "ch19 priority", channel, 19);
        chk("R2", "ch19 freq", freq_khz, 27185);
        emerg9 = 1'b0; emerg19 = 1'b0; cyc(1);
        chk("R8", "restore normal", channel, c);
        chk("R8", "flag cleared", emerg_active, 0);
    endtask

    task automatic t_emerg_vs_scan();
        int c1;
        start_scan(1'b1, c1);
        cyc(ST - 1);
        emerg9 = 1'b1; cyc(1);
        chk("R8", "emerg at step edge", channel, 9);
        chk("R8", "scan cancelled", scanning, 0);
        emerg9 = 1'b0; cyc(1);
        chk("R8", "step at emerg edge dropped", channel, c1);
        cyc(2 * ST);
        chk("R8", "no scan after emerg", channel, c1);
    endtask

    task automatic t_hold();
        int c1;
        start_scan(1'b1, c1);
        hold_n = 1'b0; cyc(1);
        chk("R9", "hold flag", in_hold, 1);
        chk("R9", "hold channel", channel, 0);
        chk("R9", "hold freq", freq_khz, 0);
        chk("R9", "hold cancels scan", scanning, 0);
        tap_up();
        tap_mem(5'b00001, 1'b0);
        emerg19 = 1'b1; cyc(1);
        chk("R9", "emerg ignored in hold", channel, 0);
        chk("R9", "no emerg flag in hold", emerg_active, 0);
        emerg19 = 1'b0; cyc(1);
        hold_n = 1'b1; cyc(1);
        chk("R9", "restore after hold", channel, c1);
        cyc(2 * ST);
        chk("R9", "no scan after hold", channel, c1);
    endtask

    task automatic t_transmit();
        tx_n = 1'b0; cyc(1);
        chk("R10", "transmit on", transmit, 1);
        tx_n = 1'b1; cyc(1);
        chk("R10", "transmit off", transmit, 0);
    endtask

    task automatic t_reset_again();
        tap_up(); tap_mem(5'b10000, 1'b1); tx_n = 1'b0; cyc(1);
        do_reset();
        tx_n = 1'b1;
        chk("R1", "channel after re-reset", channel, 1);
        tap_up();
        tap_mem(5'b10000, 1'b0);
        chk("R1", "slot 4 cleared", channel, 1);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: all requirements, actual timeout expected finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        cyc(1);
        t_reset();
        t_walk_table();
        t_step_corners();
        t_scan();
        t_presets();
        t_emergency();
        t_emerg_vs_scan();
        t_hold();
        t_transmit();
        t_reset_again();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule